// File: doc/BRIEF.md
# Three-Bit Full-Cycle Sequence Generator

This block holds a three-bit state register that walks through all eight three-bit codes in one fixed cyclic order, the all-zero code included. Each step shifts the register one place toward its least significant bit and fills the top bit from a nonlinear feedback term. Unlike a linear shift register sequence, no code is excluded, so the cycle has length eight and there is no lock-up code.

A synchronous reset puts the register at 000. A synchronous seed load can place the register on any code. An advance enable steps it, and a one-cycle wrap flag marks the step that closes the cycle. Typical uses are a cheap pseudo-ordered slot selector or a scrambled eight-phase counter.

Top module: `seq3_cycle_gen`

## Requirements
- R1: With `adv_en` high (and no reset or load), each rising clock edge moves `state_o` (bit 2 written leftmost) along the order 000, 100, 010, 101, 110, 111, 011, 001, then back to 000.
- R2: While `rst` is high at a rising edge, `state_o` becomes 000 and `wrap_o` becomes 0.
- R3: An advance from 001 gives 000 and raises `wrap_o` in the same cycle as the new state.
- R4: With `rst`, `seed_ld` and `adv_en` all low, `state_o` keeps its value and `wrap_o` is 0.
- R5: With `seed_ld` high and `rst` low, `state_o` takes `seed_val` at the edge, whether `adv_en` is high or not, and `wrap_o` is 0.
- R6: `rst` wins over `seed_ld`: both high gives 000, not the seed.
- R7: `wrap_o` is high for exactly one cycle per wrap and is low after every other edge, including a load of 000 and a hold at 000.
- R8: From any of the eight codes, eight advances visit eight distinct codes and return to the starting code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Step the sequence by one code |
| seed_ld | input | 1 | Load `seed_val` into the state |
| seed_val | input | 3 | Code to load |
| state_o | output | 3 | Current state code |
| wrap_o | output | 1 | High for the cycle after the 001 to 000 step |

## Verification
The bench seeds every one of the eight codes and follows eight steps against an order table, so a feedback term wrong for even one code breaks the chain or shortens the cycle, and a design that stalls at 000 as a plain linear sequence would is caught at once. It collides reset with load and load with advance; a swapped priority would show the seed, or a stepped seed, instead of the expected code. It also holds at 000 and loads 000 directly, where a flag decoded from the state rather than from the step would rise falsely, and holds after a wrap, where a sticky flag would stay high.

// File: rtl/seq3_pkg.sv
package seq3_pkg;
    localparam int STW = 3;
    localparam logic [STW-1:0] ZERO_CODE = '0;
    localparam logic [STW-1:0] LAST_CODE = {{(STW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STW-1:0] state;
        logic           wrap;
    } seq3_regs_t;
endpackage

// File: rtl/seq3_feedback.sv
module seq3_feedback
    import seq3_pkg::*;
(
    input  logic [STW-1:0] cur,
    output logic [STW-1:0] nxt,
    output logic           at_last
);
    // shift path: each lower bit takes the bit above it
    for (genvar i = 0; i < STW - 1; i++) begin : g_shift
        assign nxt[i] = cur[i+1];
    end

    // nonlinear fill of the top bit; closes the cycle through 000
    assign nxt[STW-1] = cur[0] ^ (cur[1] | ~cur[2]);

    assign at_last = (cur == LAST_CODE);
endmodule

// File: rtl/seq3_cycle_gen.sv
module seq3_cycle_gen
    import seq3_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           adv_en,
    input  logic           seed_ld,
    input  logic [STW-1:0] seed_val,
    output logic [STW-1:0] state_o,
    output logic           wrap_o
);
    seq3_regs_t     r_d, r_q;
    logic [STW-1:0] step_code;
    logic           step_last;

    seq3_feedback u_fb (
        .cur     (r_q.state),
        .nxt     (step_code),
        .at_last (step_last)
    );

    always_comb begin
        r_d = r_q;
        r_d.wrap = 1'b0;
        if (rst) begin
            r_d.state = ZERO_CODE;
        end else if (seed_ld) begin
            r_d.state = seed_val;
        end else if (adv_en) begin
            r_d.state = step_code;
            r_d.wrap  = step_last;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign wrap_o  = r_q.wrap;

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == ZERO_CODE && !wrap_o));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(seed_ld) && !$past(adv_en))
        |-> (state_o == $past(state_o) && !wrap_o));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(seed_ld)) |-> (state_o == $past(seed_val) && !wrap_o));

    // R3
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(seed_ld) && $past(adv_en) && $past(state_o) == LAST_CODE)
        |-> (state_o == ZERO_CODE && wrap_o));

    // R7
    wrap_only_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (state_o == ZERO_CODE && $past(state_o) == LAST_CODE));
endmodule

// File: tb/tb_seq3_cycle_gen.sv
module tb_seq3_cycle_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_en = 1'b0;
    logic       seed_ld = 1'b0;
    logic [2:0] seed_val = 3'b000;
    logic [2:0] state_o;
    logic       wrap_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    seq3_cycle_gen dut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .seed_ld(seed_ld),
        .seed_val(seed_val), .state_o(state_o), .wrap_o(wrap_o)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] order_at(int idx);
        case (idx % 8)
            0: return 3'b000; 1: return 3'b100; 2: return 3'b010; 3: return 3'b101;
            4: return 3'b110; 5: return 3'b111; 6: return 3'b011; default: return 3'b001;
        endcase
    endfunction

    function automatic logic [2:0] ref_next(logic [2:0] s);
        for (int i = 0; i < 8; i++) if (order_at(i) == s) return order_at(i + 1);
        return 3'bxxx;
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive on falling edge, then sample on the next falling edge
    task automatic cyc(bit r, bit ld, bit adv, logic [2:0] sv);
        rst = r; seed_ld = ld; adv_en = adv; seed_val = sv;
        @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(1, 0, 1, 3'b000);
        chk("R2 reset state", {state_o, wrap_o}, 4'b0000);
    endtask

    task automatic t_cycles;
        for (int s = 0; s < 8; s++) begin
            logic [2:0] exp;
            logic [7:0] seen;
            exp = 3'(s);
            seen = '0;
            cyc(0, 1, 0, 3'(s));
            chk("R5 seed load", {state_o, wrap_o}, {exp, 1'b0});
            for (int k = 0; k < 8; k++) begin
                logic [2:0] prev;
                prev = exp;
                exp = ref_next(exp);
                cyc(0, 0, 1, 3'b000);
                seen[state_o] = 1'b1;
                chk("R1 step", {state_o, 1'b0}, {exp, 1'b0});
                chk(prev == 3'b001 ? "R3 wrap on 001->000" : "R7 no wrap",
                    {3'b000, wrap_o}, {3'b000, prev == 3'b001});
            end
            chk("R8 back to start", {state_o, 1'b0}, {3'(s), 1'b0});
            chk("R8 eight distinct", {3'b000, &seen}, 4'b0001);
        end
    endtask

    task automatic t_hold_and_wrap;
        cyc(0, 1, 0, 3'b001);
        cyc(0, 0, 1, 3'b000);
        chk("R3 wrap pulse", {state_o, wrap_o}, 4'b0001);
        cyc(0, 0, 0, 3'b000);
        chk("R7 wrap one cycle", {state_o, wrap_o}, 4'b0000);
        cyc(0, 0, 0, 3'b000);
        chk("R4 hold at zero", {state_o, wrap_o}, 4'b0000);
        cyc(0, 1, 0, 3'b110);
        cyc(0, 0, 0, 3'b011);
        cyc(0, 0, 0, 3'b011);
        chk("R4 hold ignores seed_val", {state_o, wrap_o}, 4'b1100);
    endtask

    task automatic t_priority;
        cyc(0, 1, 1, 3'b011);
        chk("R5 load over advance", {state_o, wrap_o}, 4'b0110);
        cyc(0, 1, 1, 3'b000);
        chk("R7 load zero no wrap", {state_o, wrap_o}, 4'b0000);
        cyc(0, 1, 0, 3'b101);
        cyc(1, 1, 1, 3'b111);
        chk("R6 reset over load", {state_o, wrap_o}, 4'b0000);
        cyc(0, 0, 1, 3'b000);
        chk("R1 step after reset", {state_o, wrap_o}, 4'b1000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cycles();
        t_hold_and_wrap();
        t_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule